// File: doc/BRIEF.md
# Configurable SPI Master Byte Engine

A full-duplex serial-peripheral master that exchanges one byte per transfer. One byte is shifted out on MOSI while one byte is captured from MISO. A host programs the clock idle level, the capture edge, the bit order and a rate setting, then writes the data register to start an exchange. When the exchange ends, a sticky completion flag sets. The byte captured from the peripheral is read back from the same data register.

The serial clock rate comes from a phase accumulator. Each system cycle adds `(256 + M) << E`, clamped, into a 27-bit accumulator, and every carry out of that accumulator is one serial-clock half period. Chip select is driven outside the block. Only master operation exists.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset, SCK and MOSI are 0, busy and done are 0, and every register reads 0x00.
- R2: The register map has four addresses. Address 0 (config) holds the idle level in bit 7, the capture phase in bit 6, the MSB-first select in bit 5 and the 5-bit rate exponent E in bits 4:0. Address 1 holds the 8-bit rate mantissa M. Address 2 is the data register. Address 3 is status, with done in bit 0 and busy in bit 1. Config and mantissa read back as written.
- R3: Whenever no exchange runs, SCK equals the idle-level bit (0 = rests low, 1 = rests high).
- R4: With phase 0, the first data bit is on MOSI before the first SCK edge, data is captured on edges 1, 3, 5… and changed on edges 2, 4…. With phase 1, data changes on edges 1, 3… and is captured on edges 2, 4….
- R5: When bit 5 of the config register is 1, bit 7 goes out first. When it is 0, bit 0 goes out first. The captured byte uses the same order.
- R6: An exchange makes exactly 16 SCK edges. Each half period lasts the floor or the ceiling of 2^27 / ((256+M)·2^E) system cycles. For exact quotients, the first edge comes that many cycles after the write is captured.
- R7: A half period never lasts fewer than 2 system cycles, whatever E and M are.
- R8: Busy reads 1 from the cycle after the data write until the last SCK edge. A data write while busy has no effect on the exchange.
- R9: Done sets on the last SCK edge, in the same cycle that busy falls. It stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R10: After the exchange, reading the data register returns the byte captured from MISO.
- R11: After the last edge, SCK rests at the idle level and MOSI keeps the last bit it sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A data write is captured on one rising edge, and busy is visible in the cycle right after it. When the quotient is exact, SCK edges come at whole multiples of the half period after that capture edge. Busy falls, done rises and the captured byte becomes readable on the rising edge that makes the 16th SCK toggle. The bench drives inputs on falling edges and timestamps every SCK change at the falling edge after it. It compares the first-edge delay and every edge spacing against the computed half period. Result registers are read only after busy is seen low, so every read lands after the edge where that value is due.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_MANT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_STAT = 2'd3
  } regAddr_t;

  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic load;
    logic toggle;
    logic sample;
    logic drive;
  } dpStrobe_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic msbFirst;
  } frameCfg_t;

endpackage

// File: rtl/spi_eng_rate.sv
`timescale 1ns/1ps
module spi_eng_rate #(
  parameter int EXP_W    = 5,
  parameter int MANT_W   = 8,
  parameter int ACC_W    = 27,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [EXP_W-1:0]  rateExp,
  input  logic [MANT_W-1:0] rateMant,
  output logic              tick
);
  localparam int SHIFT_W = MANT_W + 1 + (1 << EXP_W) - 1;
  localparam int CAP_LOG = ACC_W - $clog2(MIN_HALF);
  localparam logic [SHIFT_W-1:0] CAP = SHIFT_W'(1) << CAP_LOG;

  logic [SHIFT_W-1:0] scaled;
  logic [ACC_W-1:0]   inc;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W:0]     sum;

  assign scaled = SHIFT_W'({1'b1, rateMant}) << rateExp;
  assign inc    = (scaled > CAP) ? CAP[ACC_W-1:0] : scaled[ACC_W-1:0];
  assign sum    = {1'b0, acc} + {1'b0, inc};
  assign tick   = run & sum[ACC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     acc <= '0;
    else if (!run) acc <= '0;
    else           acc <= sum[ACC_W-1:0];
  end

  AST_HALF_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R7

endmodule

// File: rtl/spi_eng_ctrl.sv
`timescale 1ns/1ps
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EXP_W  = 5,
  parameter int MANT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              tick,
  output frameCfg_t         cfg,
  output logic [EXP_W-1:0]  rateExp,
  output logic [MANT_W-1:0] rateMant,
  output logic              busy,
  output dpStrobe_t         strobe
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);
  localparam int CFG_PAD = DATA_W - 3 - EXP_W;

  regAddr_t          addr;
  frameCfg_t         cfgQ;
  logic [EXP_W-1:0]  expQ;
  logic [MANT_W-1:0] mantQ;
  logic              busyQ;
  logic              doneQ;
  logic [EDGE_W-1:0] edgeCnt;
  logic              dataWr;
  logic              clearDone;
  logic              lastEdge;
  logic              finish;

  assign addr      = regAddr_t'(regAddr);
  assign dataWr    = regWr && (addr == ADDR_DATA);
  assign clearDone = regWr && (addr == ADDR_STAT) && regWrData[0];
  assign lastEdge  = (edgeCnt == EDGE_LAST);
  assign finish    = busyQ && tick && lastEdge;

  always_comb begin
    strobe        = '0;
    strobe.load   = dataWr && !busyQ;
    strobe.toggle = busyQ && tick;
    strobe.sample = strobe.toggle && (edgeCnt[0] == cfgQ.cpha);
    strobe.drive  = strobe.toggle && (edgeCnt[0] != cfgQ.cpha) && !lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      expQ  <= '0;
      mantQ <= '0;
    end else if (regWr) begin
      if (addr == ADDR_CFG) begin
        cfgQ.cpol     <= regWrData[DATA_W-1];
        cfgQ.cpha     <= regWrData[DATA_W-2];
        cfgQ.msbFirst <= regWrData[DATA_W-3];
        expQ          <= regWrData[EXP_W-1:0];
      end
      if (addr == ADDR_MANT) mantQ <= regWrData[MANT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      edgeCnt <= '0;
    end else begin
      if (strobe.load) begin
        busyQ   <= 1'b1;
        edgeCnt <= '0;
      end else if (strobe.toggle) begin
        edgeCnt <= edgeCnt + EDGE_W'(1);
      end
      if (finish) busyQ <= 1'b0;
      if (finish)         doneQ <= 1'b1;
      else if (clearDone) doneQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CFG:  regRdData = {cfgQ.cpol, cfgQ.cpha, cfgQ.msbFirst,
                              {CFG_PAD{1'b0}}, expQ};
      ADDR_MANT: regRdData = DATA_W'(mantQ);
      ADDR_DATA: regRdData = rxByte;
      default:   regRdData = DATA_W'({busyQ, doneQ});
    endcase
  end

  assign cfg      = cfgQ;
  assign rateExp  = expQ;
  assign rateMant = mantQ;
  assign busy     = busyQ;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ && !clearDone |=> doneQ); // R9
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ); // R9
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !tick |=> busyQ && (edgeCnt == $past(edgeCnt))); // R8

endmodule

// File: rtl/spi_eng_dp.sv
`timescale 1ns/1ps
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  frameCfg_t         cfg,
  input  logic              busy,
  input  logic [DATA_W-1:0] loadData,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte
);
  logic              phaseQ;
  logic              mosiQ;
  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;

  function automatic logic headBit(input logic [DATA_W-1:0] v, input logic msb);
    return msb ? v[DATA_W-1] : v[0];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic msb);
    return msb ? (v << 1) : (v >> 1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      mosiQ  <= 1'b0;
      txSh   <= '0;
      rxSh   <= '0;
    end else begin
      if (strobe.load) begin
        phaseQ <= 1'b0;
        if (!cfg.cpha) begin
          mosiQ <= headBit(loadData, cfg.msbFirst);
          txSh  <= advance(loadData, cfg.msbFirst);
        end else begin
          txSh  <= loadData;
        end
      end else begin
        if (strobe.toggle) phaseQ <= ~phaseQ;
        if (strobe.drive) begin
          mosiQ <= headBit(txSh, cfg.msbFirst);
          txSh  <= advance(txSh, cfg.msbFirst);
        end
        if (strobe.sample) begin
          rxSh <= cfg.msbFirst ? {rxSh[DATA_W-2:0], miso}
                               : {miso, rxSh[DATA_W-1:1]};
        end
      end
    end
  end

  assign sck    = cfg.cpol ^ phaseQ;
  assign mosi   = mosiQ;
  assign rxByte = rxSh;

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == cfg.cpol)); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(mosiQ)); // R11
  AST_RX_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(rxSh)); // R10

endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int EXP_W    = 5,
  parameter int MANT_W   = 8,
  parameter int ACC_W    = 27,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  frameCfg_t         cfg;
  dpStrobe_t         strobe;
  logic [EXP_W-1:0]  rateExp;
  logic [MANT_W-1:0] rateMant;
  logic              busy;
  logic              tick;
  logic [DATA_W-1:0] rxByte;

  spi_eng_ctrl #(.DATA_W(DATA_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxByte(rxByte),
    .tick(tick), .cfg(cfg), .rateExp(rateExp), .rateMant(rateMant),
    .busy(busy), .strobe(strobe)
  );

  spi_eng_rate #(.EXP_W(EXP_W), .MANT_W(MANT_W), .ACC_W(ACC_W),
                 .MIN_HALF(MIN_HALF)) uRate (
    .clk(clk), .rstN(rstN), .run(busy), .rateExp(rateExp),
    .rateMant(rateMant), .tick(tick)
  );

  spi_eng_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .busy(busy),
    .loadData(regWrData), .miso(miso), .sck(sck), .mosi(mosi),
    .rxByte(rxByte)
  );

endmodule

// File: tb/tb_spi_byte_engine.sv
`timescale 1ns/1ps
module tb_spi_byte_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sck, mosi;
  logic       misoQ = 1'b0;

  int nRun = 0, nFail = 0, cyc = 0, writeCyc = 0;

  // slave model state, written only by the negedge process
  int armSeq = 0, armSeen = 0;
  bit armPha = 0, armMsb = 0;
  logic [7:0] armTx = 8'd0;
  logic [7:0] slvRx = 8'd0;
  int edgeN = 0, sIdx = 0, dIdx = 0;
  int firstEdgeCyc = 0, lastEdgeCyc = 0, minInt = 0, maxInt = 0;
  logic prevSck = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_byte_engine dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck),
    .mosi(mosi), .miso(misoQ)
  );

  function automatic int bp(input bit msb, input int i);
    return msb ? 7 - i : i;
  endfunction

  always @(negedge clk) begin
    if (armSeq != armSeen) begin
      armSeen = armSeq;
      edgeN = 0; sIdx = 0; slvRx = 8'd0;
      minInt = 1000000; maxInt = 0;
      dIdx = armPha ? -1 : 0;
      if (!armPha) misoQ = armTx[bp(armMsb, 0)];
    end else if (rstN && sck !== prevSck) begin
      if (edgeN == 0) firstEdgeCyc = cyc;
      else begin
        if (cyc - lastEdgeCyc < minInt) minInt = cyc - lastEdgeCyc;
        if (cyc - lastEdgeCyc > maxInt) maxInt = cyc - lastEdgeCyc;
      end
      lastEdgeCyc = cyc;
      if ((edgeN % 2) == int'(armPha)) begin
        if (sIdx < 8) slvRx[bp(armMsb, sIdx)] = mosi;
        sIdx++;
      end else begin
        dIdx++;
        if (dIdx >= 0 && dIdx < 8) misoQ = armTx[bp(armMsb, dIdx)];
      end
      edgeN++;
    end
    prevSck = sck;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    writeCyc = cyc;
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // expH > 0: exact half period; expH < 0: spacing must stay within 2..3
  task automatic xfer(input bit pol, input bit pha, input bit msb,
                      input int e, input int m, input logic [7:0] tx,
                      input logic [7:0] sb, input int expH, input bit extraWr);
    logic [7:0] st, rd;
    int wc;
    regWrite(2'd3, 8'h01);
    regWrite(2'd0, {pol, pha, msb, e[4:0]});
    regWrite(2'd1, m[7:0]);
    armPha = pha; armMsb = msb; armTx = sb; armSeq++;
    @(negedge clk); @(negedge clk);
    check(sck == pol, "R3", "idle sck before start", int'(sck), int'(pol));
    regWrite(2'd2, tx);
    wc = writeCyc;
    regRead(2'd3, st);
    check(st[1] == 1'b1, "R8", "busy after data write", int'(st[1]), 1);
    if (extraWr) begin
      repeat (3) @(negedge clk);
      regWrite(2'd2, ~tx);
    end
    for (int t = 0; t < 5000; t++) begin
      regRead(2'd3, st);
      if (!st[1]) break;
      @(negedge clk);
    end
    check(edgeN == 16, "R6", "sck edge count", edgeN, 16);
    check(slvRx == tx, "R4 R5", "byte seen by peripheral", int'(slvRx), int'(tx));
    regRead(2'd2, rd);
    check(rd == sb, "R10", "captured byte readback", int'(rd), int'(sb));
    check(sck == pol, "R11", "sck at idle after end", int'(sck), int'(pol));
    check(mosi == (msb ? tx[0] : tx[7]), "R11", "mosi holds last bit",
          int'(mosi), int'(msb ? tx[0] : tx[7]));
    check(st[0] == 1'b1, "R9", "done after end", int'(st[0]), 1);
    if (expH > 0) begin
      check(firstEdgeCyc - wc == expH, "R6", "first edge delay", firstEdgeCyc - wc, expH);
      check(minInt == expH && maxInt == expH, "R6 R7", "half period", minInt, expH);
    end else if (expH < 0) begin
      check(minInt >= 2 && maxInt <= 3, "R6 R7", "uneven half period range", maxInt, 3);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      regRead(a[1:0], v);
      check(v == 8'h00, "R1", "register reset value", int'(v), 0);
    end
    check(sck == 1'b0 && mosi == 1'b0, "R1", "pins at reset", int'({sck, mosi}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: register readback
    regWrite(2'd0, 8'hB5);
    regRead(2'd0, v);
    check(v == 8'hB5, "R2", "config readback", int'(v), 8'hB5);
    regWrite(2'd1, 8'h3C);
    regRead(2'd1, v);
    check(v == 8'h3C, "R2", "mantissa readback", int'(v), 8'h3C);
    check(sck == 1'b1, "R3", "idle high when polarity 1", int'(sck), 1);

    // every mode and order, three patterns each, half period 2
    for (int cfgIdx = 0; cfgIdx < 8; cfgIdx++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] tx, sb;
        tx = (8'h01 << (cfgIdx % 8)) ^ (p == 0 ? 8'hA5 : (p == 1 ? 8'h0F : 8'hE2));
        sb = ~tx ^ 8'(cfgIdx * 37 + p);
        xfer(cfgIdx[2], cfgIdx[1], cfgIdx[0], 18, 0, tx, sb, 2, 1'b0);
      end
    end

    // R6: exact rates; R7: clamp at the fastest setting
    xfer(1'b0, 1'b0, 1'b1, 17, 0, 8'h96, 8'h3D, 4, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 16, 0, 8'h4B, 8'hC8, 8, 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 15, 0, 8'h71, 8'h0E, 16, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 31, 255, 8'hD2, 8'h59, 2, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 17, 128, 8'h6A, 8'hB3, -1, 1'b0);

    // R8: a data write during the exchange is ignored
    xfer(1'b0, 1'b0, 1'b1, 16, 0, 8'hC3, 8'h5A, 8, 1'b1);

    // R9: done stays set until a status write with bit 0 = 1
    repeat (20) @(negedge clk);
    regRead(2'd3, v);
    check(v[0] == 1'b1, "R9", "done holds while idle", int'(v[0]), 1);
    regWrite(2'd3, 8'h00);
    regRead(2'd3, v);
    check(v[0] == 1'b1, "R9", "status write 0 keeps done", int'(v[0]), 1);
    regWrite(2'd3, 8'h01);
    regRead(2'd3, v);
    check(v == 8'h00, "R9", "status write 1 clears done", int'(v), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule